// File: doc/BRIEF.md
# Accumulator ALU Execute Unit

This block is the execute stage of a small 8-bit accumulator machine with a 14-bit instruction word. Each cycle in which `in_vld` is high, it takes the instruction, the working register W, the byte read from the addressed file register, and the current carry, digit-carry and zero flags. It decodes the instruction and computes the result byte. It also decides whether that byte goes back to W or to the file register, produces the new flag values and raises a skip request for the conditional forms.

Instruction fetch, the program counter, skip sequencing and the register file all sit outside the block. The surrounding pipeline uses `file_we` and `w_we` as write strobes, takes the target location from `addr_q`, and loads the three flag outputs back into its status register. A flag that an instruction does not touch is copied from its input to its output. With the default `REG_OUT = 1`, every output is registered, so the results appear one clock after the inputs.

Top module: `acc_exec_unit`

## Requirements
- R1: While `rst_n` is low, `vld_q`, `file_we`, `w_we` and `skip_q` are all 0.
- R2: An instruction presented with `in_vld` high is reported in the next cycle with `vld_q` high. A cycle with `in_vld` low raises no write strobe and no skip in the next cycle.
- R3: `addr_q` carries instruction bits 6:0. `file_we` and `w_we` are never high together, and `to_file` is 1 exactly when the write goes to the file register. For the byte class (bits 13:12 = 00), bit 7 picks the target: 1 selects the file register and 0 selects W.
- R4: The byte codes add (bits 11:8 = 0111) and subtract (0010) compute f+W and f−W. Both update C, DC and Z. For add, C is the carry out of bit 7 and DC is the carry out of bit 3. For subtract, C = 1 when f ≥ W (no borrow) and DC = 1 when the low nibble of f ≥ the low nibble of W.
- R5: These byte codes update only Z, which is set when the result is zero: and (0101), or (0100), xor (0110), complement (1001), increment (1010), decrement (0011) and move f (1000).
- R6: Rotate left (1101) produces {f[6:0], C} and rotate right (1100) produces {C, f[7:1]}. Each updates only C, which takes the bit shifted out.
- R7: Swap (1110) exchanges the two nibbles of f. Byte code 0000 with bit 7 = 1 writes W to the file register. Neither changes any flag.
- R8: Byte code 0001 writes 0 and sets Z. With bit 7 = 1 the write goes to the file register; with bit 7 = 0 it goes to W.
- R9: In the bit class (bits 13:12 = 01), operation bits 11:10 = 00 clears and 01 sets bit [9:7] of f. The result is written to the file register and no flag changes.
- R10: Bit operations 10 and 11 write nothing and change no flag. They raise `skip_q` when the tested bit is 0 (for 10) or 1 (for 11).
- R11: Byte codes 1011 and 1111 compute f−1 and f+1 with a write target chosen by bit 7. They change no flag and raise `skip_q` when the result is zero.
- R12: In the literal class (bits 13:12 = 11), the literal k is bits 7:0 and the result always goes to W. Bits 11:8 select the operation: 00xx moves k (no flags); 1000 is or, 1001 is and and 1010 is xor (Z only); 110x computes k−W and 111x computes k+W (C, DC, Z with the same rules as R4).
- R13: These encodings write nothing, raise no skip and pass all flags through: class 10, byte code 0000 with bit 7 = 0, and literal codes 01xx and 1011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Instruction valid this cycle |
| instr | input | 14 | Instruction word |
| w_in | input | 8 | Working register value |
| f_in | input | 8 | Operand byte from the addressed file register |
| c_in | input | 1 | Current carry flag |
| dc_in | input | 1 | Current digit-carry flag |
| z_in | input | 1 | Current zero flag |
| vld_q | output | 1 | Result valid |
| res_q | output | 8 | Result byte |
| to_file | output | 1 | Target select: 1 file register, 0 W |
| file_we | output | 1 | File register write strobe |
| w_we | output | 1 | W write strobe |
| addr_q | output | 7 | File address for the write |
| c_q | output | 1 | New carry flag |
| dc_q | output | 1 | New digit-carry flag |
| z_q | output | 1 | New zero flag |
| skip_q | output | 1 | Skip request for the next instruction |

## Verification
The assertions assume the registered variant and that each input holds a known value in every cycle where `in_vld` is high. The flag pass-through properties compare against the flags sampled one cycle earlier. The stimulus drives every input on the falling edge and holds it through the following rising edge. It draws full 14-bit instruction words, so unused and out-of-scope encodings are covered along with the defined ones. Directed vectors add the carry, borrow, nibble and zero boundaries.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

   typedef enum logic [4:0] {
      OP_NOP,
      OP_PASSW,
      OP_CLR,
      OP_ADD,
      OP_SUB,
      OP_AND,
      OP_OR,
      OP_XOR,
      OP_COM,
      OP_INC,
      OP_DEC,
      OP_MOV,
      OP_RL,
      OP_RR,
      OP_SWAP,
      OP_BCLR,
      OP_BSET,
      OP_BTST
   } alu_op_e;

   typedef struct packed {
      alu_op_e op;
      logic    use_lit;
      logic    dest_file;
      logic    wr;
      logic    upd_c;
      logic    upd_dc;
      logic    upd_z;
      logic    skip_zero;
      logic    skip_bit;
      logic    skip_pol;
   } exec_ctl_t;

endpackage

// File: rtl/acc_exec_decode.sv
module acc_exec_decode
   import acc_exec_pkg::*;
#(
   parameter int ADDR_W  = 7,
   parameter int INSTR_W = ADDR_W + 7,
   parameter int BIDX_W  = 3
) (
   input  logic [INSTR_W-1:0] instr,
   output exec_ctl_t          ctl,
   output logic [BIDX_W-1:0]  bidx
);
   localparam int CLS_LSB = INSTR_W - 2;
   localparam int OP_LSB  = INSTR_W - 6;

   logic [1:0] cls;
   logic [3:0] op4;
   logic       dbit;

   assign cls  = instr[CLS_LSB +: 2];
   assign op4  = instr[OP_LSB +: 4];
   assign dbit = instr[ADDR_W];
   assign bidx = instr[ADDR_W +: BIDX_W];

   always_comb begin
      ctl.op        = OP_NOP;
      ctl.use_lit   = 1'b0;
      ctl.dest_file = 1'b0;
      ctl.wr        = 1'b0;
      ctl.upd_c     = 1'b0;
      ctl.upd_dc    = 1'b0;
      ctl.upd_z     = 1'b0;
      ctl.skip_zero = 1'b0;
      ctl.skip_bit  = 1'b0;
      ctl.skip_pol  = 1'b0;
      case (cls)
         2'b00: begin
            ctl.dest_file = dbit;
            ctl.wr        = 1'b1;
            ctl.upd_z     = 1'b1;
            case (op4)
               4'h0: begin
                  ctl.op    = OP_PASSW;
                  ctl.wr    = dbit;
                  ctl.upd_z = 1'b0;
               end
               4'h1: ctl.op = OP_CLR;
               4'h2: begin
                  ctl.op     = OP_SUB;
                  ctl.upd_c  = 1'b1;
                  ctl.upd_dc = 1'b1;
               end
               4'h3: ctl.op = OP_DEC;
               4'h4: ctl.op = OP_OR;
               4'h5: ctl.op = OP_AND;
               4'h6: ctl.op = OP_XOR;
               4'h7: begin
                  ctl.op     = OP_ADD;
                  ctl.upd_c  = 1'b1;
                  ctl.upd_dc = 1'b1;
               end
               4'h8: ctl.op = OP_MOV;
               4'h9: ctl.op = OP_COM;
               4'hA: ctl.op = OP_INC;
               4'hB: begin
                  ctl.op        = OP_DEC;
                  ctl.upd_z     = 1'b0;
                  ctl.skip_zero = 1'b1;
               end
               4'hC: begin
                  ctl.op    = OP_RR;
                  ctl.upd_z = 1'b0;
                  ctl.upd_c = 1'b1;
               end
               4'hD: begin
                  ctl.op    = OP_RL;
                  ctl.upd_z = 1'b0;
                  ctl.upd_c = 1'b1;
               end
               4'hE: begin
                  ctl.op    = OP_SWAP;
                  ctl.upd_z = 1'b0;
               end
               default: begin
                  ctl.op        = OP_INC;
                  ctl.upd_z     = 1'b0;
                  ctl.skip_zero = 1'b1;
               end
            endcase
         end
         2'b01: begin
            ctl.dest_file = 1'b1;
            case (op4[3:2])
               2'b00: begin
                  ctl.op = OP_BCLR;
                  ctl.wr = 1'b1;
               end
               2'b01: begin
                  ctl.op = OP_BSET;
                  ctl.wr = 1'b1;
               end
               default: begin
                  ctl.op       = OP_BTST;
                  ctl.skip_bit = 1'b1;
                  ctl.skip_pol = op4[2];
               end
            endcase
         end
         2'b11: begin
            ctl.use_lit = 1'b1;
            casez (op4)
               4'b00??: begin
                  ctl.op = OP_MOV;
                  ctl.wr = 1'b1;
               end
               4'b1000: begin
                  ctl.op    = OP_OR;
                  ctl.wr    = 1'b1;
                  ctl.upd_z = 1'b1;
               end
               4'b1001: begin
                  ctl.op    = OP_AND;
                  ctl.wr    = 1'b1;
                  ctl.upd_z = 1'b1;
               end
               4'b1010: begin
                  ctl.op    = OP_XOR;
                  ctl.wr    = 1'b1;
                  ctl.upd_z = 1'b1;
               end
               4'b110?: begin
                  ctl.op     = OP_SUB;
                  ctl.wr     = 1'b1;
                  ctl.upd_c  = 1'b1;
                  ctl.upd_dc = 1'b1;
                  ctl.upd_z  = 1'b1;
               end
               4'b111?: begin
                  ctl.op     = OP_ADD;
                  ctl.wr     = 1'b1;
                  ctl.upd_c  = 1'b1;
                  ctl.upd_dc = 1'b1;
                  ctl.upd_z  = 1'b1;
               end
               default: ctl.op = OP_NOP;
            endcase
         end
         default: ctl.op = OP_NOP;
      endcase
   end

endmodule

// File: rtl/acc_exec_alu.sv
module acc_exec_alu
   import acc_exec_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int BIDX_W = 3
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] w,
   input  logic              c_in,
   input  logic [BIDX_W-1:0] bidx,
   output logic [DATA_W-1:0] res,
   output logic              cy,
   output logic              dcy,
   output logic              tbit
);
   localparam int HALF = DATA_W / 2;

   logic              sub;
   logic [DATA_W-1:0] b_op;
   logic [DATA_W:0]   full_sum;
   logic [HALF:0]     nib_sum;
   logic [DATA_W-1:0] mask;

   assign sub      = (op == OP_SUB);
   assign b_op     = sub ? ~w : w;
   assign full_sum = {1'b0, a} + {1'b0, b_op} + {{DATA_W{1'b0}}, sub};
   assign nib_sum  = {1'b0, a[HALF-1:0]} + {1'b0, b_op[HALF-1:0]} + {{HALF{1'b0}}, sub};
   assign dcy      = nib_sum[HALF];
   assign tbit     = a[bidx];

   genvar gi;
   generate
      for (gi = 0; gi < DATA_W; gi++) begin : g_mask
         assign mask[gi] = (bidx == gi[BIDX_W-1:0]);
      end
   endgenerate

   always_comb begin
      res = a;
      cy  = full_sum[DATA_W];
      case (op)
         OP_PASSW: res = w;
         OP_CLR:   res = '0;
         OP_ADD,
         OP_SUB:   res = full_sum[DATA_W-1:0];
         OP_AND:   res = a & w;
         OP_OR:    res = a | w;
         OP_XOR:   res = a ^ w;
         OP_COM:   res = ~a;
         OP_INC:   res = a + 1'b1;
         OP_DEC:   res = a - 1'b1;
         OP_RL: begin
            res = {a[DATA_W-2:0], c_in};
            cy  = a[DATA_W-1];
         end
         OP_RR: begin
            res = {c_in, a[DATA_W-1:1]};
            cy  = a[0];
         end
         OP_SWAP:  res = {a[HALF-1:0], a[DATA_W-1:HALF]};
         OP_BCLR:  res = a & ~mask;
         OP_BSET:  res = a | mask;
         default:  res = a;
      endcase
   end

endmodule

// File: rtl/acc_exec_status.sv
module acc_exec_status
   import acc_exec_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  exec_ctl_t         ctl,
   input  logic [DATA_W-1:0] res,
   input  logic              cy,
   input  logic              dcy,
   input  logic              tbit,
   input  logic              c_in,
   input  logic              dc_in,
   input  logic              z_in,
   output logic              c_out,
   output logic              dc_out,
   output logic              z_out,
   output logic              skip
);
   logic res_zero;

   assign res_zero = (res == '0);
   assign c_out    = ctl.upd_c  ? cy       : c_in;
   assign dc_out   = ctl.upd_dc ? dcy      : dc_in;
   assign z_out    = ctl.upd_z  ? res_zero : z_in;

   always_comb begin
      skip = 1'b0;
      if (ctl.skip_zero)
         skip = res_zero;
      else if (ctl.skip_bit)
         skip = (tbit == ctl.skip_pol);
   end

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
   import acc_exec_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 7,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_vld,
   input  logic [ADDR_W+6:0]   instr,
   input  logic [DATA_W-1:0]   w_in,
   input  logic [DATA_W-1:0]   f_in,
   input  logic                c_in,
   input  logic                dc_in,
   input  logic                z_in,
   output logic                vld_q,
   output logic [DATA_W-1:0]   res_q,
   output logic                to_file,
   output logic                file_we,
   output logic                w_we,
   output logic [ADDR_W-1:0]   addr_q,
   output logic                c_q,
   output logic                dc_q,
   output logic                z_q,
   output logic                skip_q
);
   localparam int INSTR_W = ADDR_W + 7;
   localparam int BIDX_W  = 3;

   generate
      if (DATA_W != ADDR_W + 1) begin : g_bad_width
         $error("acc_exec_unit: DATA_W must equal ADDR_W + 1");
      end
      if (DATA_W < 4 || DATA_W > 8 || (DATA_W % 2) != 0) begin : g_bad_data
         $error("acc_exec_unit: DATA_W must be 4, 6 or 8");
      end
   endgenerate

   exec_ctl_t         ctl;
   logic [BIDX_W-1:0] bidx;
   logic [DATA_W-1:0] operand;
   logic [DATA_W-1:0] alu_res;
   logic              alu_cy;
   logic              alu_dcy;
   logic              alu_tbit;
   logic              nx_c;
   logic              nx_dc;
   logic              nx_z;
   logic              nx_skip;
   logic              nx_fwe;
   logic              nx_wwe;

   acc_exec_decode #(
      .ADDR_W  (ADDR_W),
      .INSTR_W (INSTR_W),
      .BIDX_W  (BIDX_W)
   ) u_decode (
      .instr (instr),
      .ctl   (ctl),
      .bidx  (bidx)
   );

   assign operand = ctl.use_lit ? instr[DATA_W-1:0] : f_in;

   acc_exec_alu #(
      .DATA_W (DATA_W),
      .BIDX_W (BIDX_W)
   ) u_alu (
      .op   (ctl.op),
      .a    (operand),
      .w    (w_in),
      .c_in (c_in),
      .bidx (bidx),
      .res  (alu_res),
      .cy   (alu_cy),
      .dcy  (alu_dcy),
      .tbit (alu_tbit)
   );

   acc_exec_status #(
      .DATA_W (DATA_W)
   ) u_status (
      .ctl    (ctl),
      .res    (alu_res),
      .cy     (alu_cy),
      .dcy    (alu_dcy),
      .tbit   (alu_tbit),
      .c_in   (c_in),
      .dc_in  (dc_in),
      .z_in   (z_in),
      .c_out  (nx_c),
      .dc_out (nx_dc),
      .z_out  (nx_z),
      .skip   (nx_skip)
   );

   assign nx_fwe = in_vld & ctl.wr &  ctl.dest_file;
   assign nx_wwe = in_vld & ctl.wr & ~ctl.dest_file;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q   <= 1'b0;
               res_q   <= '0;
               to_file <= 1'b0;
               file_we <= 1'b0;
               w_we    <= 1'b0;
               addr_q  <= '0;
               c_q     <= 1'b0;
               dc_q    <= 1'b0;
               z_q     <= 1'b0;
               skip_q  <= 1'b0;
            end else begin
               vld_q   <= in_vld;
               res_q   <= alu_res;
               to_file <= ctl.dest_file;
               file_we <= nx_fwe;
               w_we    <= nx_wwe;
               addr_q  <= instr[ADDR_W-1:0];
               c_q     <= nx_c;
               dc_q    <= nx_dc;
               z_q     <= nx_z;
               skip_q  <= in_vld & nx_skip;
            end
         end
      end else begin : g_comb
         assign vld_q   = in_vld & rst_n;
         assign res_q   = alu_res;
         assign to_file = ctl.dest_file;
         assign file_we = nx_fwe & rst_n;
         assign w_we    = nx_wwe & rst_n;
         assign addr_q  = instr[ADDR_W-1:0];
         assign c_q     = nx_c;
         assign dc_q    = nx_dc;
         assign z_q     = nx_z;
         assign skip_q  = in_vld & nx_skip & rst_n;
      end
   endgenerate

endmodule

// File: rtl/acc_exec_unit_chk.sv
module acc_exec_unit_chk #(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 7,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_vld,
   input logic [ADDR_W+6:0] instr,
   input logic              c_in,
   input logic              dc_in,
   input logic              z_in,
   input logic              vld_q,
   input logic [DATA_W-1:0] res_q,
   input logic              to_file,
   input logic              file_we,
   input logic              w_we,
   input logic [ADDR_W-1:0] addr_q,
   input logic              c_q,
   input logic              dc_q,
   input logic              z_q,
   input logic              skip_q
);
   localparam int TOP = ADDR_W + 6;

   logic is_lit_wr;
   logic is_btest;
   logic is_swap;
   logic is_clr;

   assign is_lit_wr = (instr[TOP -: 2] == 2'b11) && (instr[TOP-2 -: 2] != 2'b01)
                      && (instr[TOP-2 -: 4] != 4'b1011);
   assign is_btest  = (instr[TOP -: 2] == 2'b01) && instr[TOP-2];
   assign is_swap   = (instr[TOP -: 2] == 2'b00) && (instr[TOP-2 -: 4] == 4'hE);
   assign is_clr    = (instr[TOP -: 2] == 2'b00) && (instr[TOP-2 -: 4] == 4'h1);

   generate
      if (REG_OUT) begin : g_chk
         AST_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
            !(file_we && w_we)); // R3
         AST_WE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
            (file_we |-> to_file) and (w_we |-> !to_file)); // R3
         AST_ADDR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            in_vld |=> (addr_q == $past(instr[ADDR_W-1:0]))); // R3
         AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            in_vld |=> vld_q); // R2
         AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !in_vld |=> (!file_we && !w_we && !skip_q)); // R2
         AST_BTEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld && is_btest) |=> (!file_we && !w_we && c_q == $past(c_in)
                                      && dc_q == $past(dc_in) && z_q == $past(z_in))); // R10
         AST_SWAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld && is_swap) |=> (c_q == $past(c_in) && dc_q == $past(dc_in)
                                     && z_q == $past(z_in))); // R7
         AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld && is_clr) |=> (z_q && res_q == '0)); // R8
         AST_LIT_TO_W: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld && is_lit_wr) |=> (w_we && !file_we)); // R12
      end
   endgenerate

endmodule

bind acc_exec_unit acc_exec_unit_chk #(
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .in_vld  (in_vld),
   .instr   (instr),
   .c_in    (c_in),
   .dc_in   (dc_in),
   .z_in    (z_in),
   .vld_q   (vld_q),
   .res_q   (res_q),
   .to_file (to_file),
   .file_we (file_we),
   .w_we    (w_we),
   .addr_q  (addr_q),
   .c_q     (c_q),
   .dc_q    (dc_q),
   .z_q     (z_q),
   .skip_q  (skip_q)
);

// File: tb/acc_exec_unit_tb.sv
module acc_exec_unit_tb;
   localparam int CLK_P = 10;

   typedef struct packed {
      logic       wf;
      logic       ww;
      logic [7:0] res;
      logic       c;
      logic       dc;
      logic       z;
      logic       skip;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [13:0] instr = '0;
   logic [7:0]  w_in = '0;
   logic [7:0]  f_in = '0;
   logic        c_in = 1'b0;
   logic        dc_in = 1'b0;
   logic        z_in = 1'b0;
   logic        vld_q;
   logic [7:0]  res_q;
   logic        to_file;
   logic        file_we;
   logic        w_we;
   logic [6:0]  addr_q;
   logic        c_q;
   logic        dc_q;
   logic        z_q;
   logic        skip_q;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_P/2) clk = ~clk;

   acc_exec_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .instr(instr),
      .w_in(w_in), .f_in(f_in), .c_in(c_in), .dc_in(dc_in), .z_in(z_in),
      .vld_q(vld_q), .res_q(res_q), .to_file(to_file), .file_we(file_we),
      .w_we(w_we), .addr_q(addr_q), .c_q(c_q), .dc_q(dc_q), .z_q(z_q),
      .skip_q(skip_q)
   );

   function automatic exp_t ref_model(input logic [13:0] i, input logic [7:0] w,
                                      input logic [7:0] f, input logic c,
                                      input logic dc, input logic z);
      exp_t e;
      logic [7:0] k;
      logic [8:0] wide;
      logic       d;
      logic [2:0] b;
      k = i[7:0];
      d = i[7];
      b = i[9:7];
      e = '{wf: 1'b0, ww: 1'b0, res: 8'h00, c: c, dc: dc, z: z, skip: 1'b0};
      if (i[13:12] == 2'b00) begin
         e.wf = d;
         e.ww = !d;
         case (i[11:8])
            4'h7: begin
               wide = f + w; e.res = wide[7:0]; e.c = wide[8];
               e.dc = ({1'b0, f[3:0]} + {1'b0, w[3:0]}) > 5'd15; e.z = (e.res == 0);
            end
            4'h2: begin
               e.res = f - w; e.c = (f >= w); e.dc = (f[3:0] >= w[3:0]); e.z = (e.res == 0);
            end
            4'h5: begin e.res = f & w; e.z = (e.res == 0); end
            4'h4: begin e.res = f | w; e.z = (e.res == 0); end
            4'h6: begin e.res = f ^ w; e.z = (e.res == 0); end
            4'h9: begin e.res = ~f;    e.z = (e.res == 0); end
            4'hA: begin e.res = f + 1; e.z = (e.res == 0); end
            4'h3: begin e.res = f - 1; e.z = (e.res == 0); end
            4'h8: begin e.res = f;     e.z = (e.res == 0); end
            4'hB: begin e.res = f - 1; e.skip = (e.res == 0); end
            4'hF: begin e.res = f + 1; e.skip = (e.res == 0); end
            4'hD: begin e.res = {f[6:0], c}; e.c = f[7]; end
            4'hC: begin e.res = {c, f[7:1]}; e.c = f[0]; end
            4'hE: e.res = {f[3:0], f[7:4]};
            4'h1: begin e.res = 8'h00; e.z = 1'b1; end
            default: begin
               e.res = w;
               e.ww  = 1'b0;
            end
         endcase
      end else if (i[13:12] == 2'b01) begin
         case (i[11:10])
            2'b00: begin e.res = f; e.res[b] = 1'b0; e.wf = 1'b1; end
            2'b01: begin e.res = f; e.res[b] = 1'b1; e.wf = 1'b1; end
            2'b10: e.skip = (f[b] == 1'b0);
            default: e.skip = (f[b] == 1'b1);
         endcase
      end else if (i[13:12] == 2'b11) begin
         casez (i[11:8])
            4'b00??: begin e.res = k; e.ww = 1'b1; end
            4'b1000: begin e.res = k | w; e.ww = 1'b1; e.z = (e.res == 0); end
            4'b1001: begin e.res = k & w; e.ww = 1'b1; e.z = (e.res == 0); end
            4'b1010: begin e.res = k ^ w; e.ww = 1'b1; e.z = (e.res == 0); end
            4'b110?: begin
               e.res = k - w; e.ww = 1'b1; e.c = (k >= w);
               e.dc = (k[3:0] >= w[3:0]); e.z = (e.res == 0);
            end
            4'b111?: begin
               wide = k + w; e.res = wide[7:0]; e.ww = 1'b1; e.c = wide[8];
               e.dc = ({1'b0, k[3:0]} + {1'b0, w[3:0]}) > 5'd15; e.z = (e.res == 0);
            end
            default: ;
         endcase
      end
      return e;
   endfunction

   function automatic string req_tag(input logic [13:0] i);
      if (i[13:12] == 2'b00) begin
         case (i[11:8])
            4'h7, 4'h2:                         return "R4";
            4'h5, 4'h4, 4'h6, 4'h9, 4'hA,
            4'h3, 4'h8:                         return "R5";
            4'hD, 4'hC:                         return "R6";
            4'hE:                               return "R7";
            4'h1:                               return "R8";
            4'hB, 4'hF:                         return "R11";
            default:                            return i[7] ? "R7" : "R13";
         endcase
      end else if (i[13:12] == 2'b01) begin
         return i[11] ? "R10" : "R9";
      end else if (i[13:12] == 2'b11) begin
         if (i[11:10] == 2'b01 || i[11:8] == 4'b1011) return "R13";
         return "R12";
      end
      return "R13";
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp_v);
      n_chk++;
      if (act !== exp_v) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
      end
   endtask

   task automatic run_op(input logic [13:0] i, input logic [7:0] w, input logic [7:0] f,
                         input logic c, input logic dc, input logic z);
      exp_t e;
      logic wr;
      @(negedge clk);
      instr = i; w_in = w; f_in = f; c_in = c; dc_in = dc; z_in = z; in_vld = 1'b1;
      e = ref_model(i, w, f, c, dc, z);
      wr = e.wf | e.ww;
      @(negedge clk);
      // R2: valid one cycle later
      check("R2", {15'd0, vld_q}, 16'd1);
      // R3: destination, strobes, address
      check("R3", {6'd0, file_we, w_we, (wr ? to_file : 1'b0), addr_q},
                  {6'd0, e.wf, e.ww, (wr ? e.wf : 1'b0), i[6:0]});
      check(req_tag(i), {4'd0, (wr ? res_q : 8'h00), c_q, dc_q, z_q, skip_q},
                        {4'd0, (wr ? e.res : 8'h00), e.c, e.dc, e.z, e.skip});
   endtask

   initial begin
      #(CLK_P * 200000);
      n_err++;
      $display("FAIL R2 watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd24681));
      repeat (3) @(negedge clk);
      // R1: quiet while in reset
      check("R1", {12'd0, vld_q, file_we, w_we, skip_q}, 16'd0);
      rst_n = 1'b1;

      // R4 add and subtract boundaries
      run_op(14'h0780, 8'h08, 8'h08, 1'b0, 1'b0, 1'b1);
      run_op(14'h0705, 8'h01, 8'hFF, 1'b0, 1'b0, 1'b0);
      run_op(14'h0285, 8'h05, 8'h05, 1'b0, 1'b0, 1'b0);
      run_op(14'h0205, 8'h05, 8'h03, 1'b1, 1'b1, 1'b1);
      run_op(14'h0211, 8'h01, 8'h10, 1'b0, 1'b1, 1'b0);
      // R5 logic zero results
      run_op(14'h0512, 8'hF0, 8'h0F, 1'b1, 1'b1, 1'b0);
      run_op(14'h0993, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0);
      // R6 rotates through carry
      run_op(14'h0D81, 8'h00, 8'h80, 1'b1, 1'b0, 1'b0);
      run_op(14'h0C01, 8'h00, 8'h01, 1'b0, 1'b1, 1'b1);
      // R7 swap and move W to file
      run_op(14'h0E81, 8'h00, 8'h3C, 1'b1, 1'b0, 1'b1);
      run_op(14'h00A2, 8'h5A, 8'h00, 1'b1, 1'b1, 1'b0);
      // R8 clear both targets
      run_op(14'h0183, 8'h12, 8'h34, 1'b0, 1'b0, 1'b0);
      run_op(14'h0003 | 14'h0100, 8'h12, 8'h34, 1'b0, 1'b0, 1'b0);
      // R9 bit clear/set at bit 7 and bit 0
      run_op(14'h1384, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0);
      run_op(14'h1404, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1);
      // R10 bit tests
      run_op(14'h1985, 8'h00, 8'h7F, 1'b0, 1'b0, 1'b0);
      run_op(14'h1C05, 8'h00, 8'h01, 1'b1, 1'b0, 1'b1);
      run_op(14'h1C05, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1);
      // R11 skip on zero
      run_op(14'h0B86, 8'h00, 8'h01, 1'b0, 1'b0, 1'b0);
      run_op(14'h0F06, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0);
      run_op(14'h0F06, 8'h00, 8'h10, 1'b0, 1'b0, 1'b1);
      // R12 literal ops
      run_op(14'h3E01, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0);
      run_op(14'h3C05, 8'h05, 8'h00, 1'b0, 1'b0, 1'b0);
      run_op(14'h3C03, 8'h05, 8'h00, 1'b1, 1'b1, 1'b1);
      run_op(14'h3042, 8'h11, 8'h00, 1'b1, 1'b0, 1'b1);
      // R13 no-op encodings
      run_op(14'h2123, 8'h11, 8'h22, 1'b1, 1'b0, 1'b1);
      run_op(14'h0064, 8'h11, 8'h22, 1'b0, 1'b1, 1'b0);
      run_op(14'h3477, 8'h11, 8'h22, 1'b1, 1'b1, 1'b0);
      run_op(14'h3B00, 8'h11, 8'h22, 1'b0, 1'b0, 1'b1);

      // R2: idle cycle raises nothing
      @(negedge clk);
      in_vld = 1'b0;
      @(negedge clk);
      check("R2", {12'd0, vld_q, file_we, w_we, skip_q}, 16'd0);

      for (int n = 0; n < 3000; n++) begin
         logic [31:0] r;
         r = $urandom;
         run_op(r[13:0], r[21:14], r[29:22], r[30], r[31], r[0] ^ r[5]);
      end

      @(negedge clk);
      in_vld = 1'b0;
      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule